// File: doc/BRIEF.md
# Flash Command Decoder with Autoselect and Program Sequencing

This block is the command front end of a two-bank NOR flash model. A host issues single-cycle bus writes and reads. The block watches the writes for a two-step unlock pattern followed by a command byte. Depending on the command byte, the block either switches one bank into an identification mode or arms a word program. The word program then keeps the addressed bank busy for a fixed number of clocks.

Identification mode is kept per bank. While a bank is in that mode, reads of that bank return a manufacturer code, three device identifier words and the lock state of each sector. Reads of the other bank are not affected. A reset command byte takes the addressed bank back to normal reads. Normal reads return the erased word FFFFh, because there is no storage array. While a program operation runs, every write is discarded. Reads of the busy bank return the word being programmed, with bit 7 inverted. The active-low reset input acts as the hardware reset and aborts a running program operation at once.

The word address is split into three fields. The bank field is in the top `BANK_W` bits. The sector field takes the next `SECT_W` bits. The offset field takes the low `OFS_W` bits.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: A write of AAh to low address 555h, then a write of 55h to low address 2AAh, then a write of 90h puts the bank named by the bank field of that third write into identification mode. The low address is `addr_i[10:0]`, and the command byte is `wdata_i[7:0]`.
- R2: A bank in identification mode answers any number of reads without a new command. Offset 00h returns 0001h, and offsets 01h, 0Eh and 0Fh return the three device identifier words. The offset is compared with the offset field only, in any sector.
- R3: In identification mode, offset 02h returns 0001h when the sector is locked and 0000h when it is unlocked. The sector is the one named by the bank and sector fields, and its lock bit is `sect_lock_i[{bank,sector}]`.
- R4: In identification mode, any other offset returns 0000h. A bank that is not in identification mode and not busy returns FFFFh. Identification mode in one bank does not change reads of the other bank.
- R5: A write whose command byte is F0h returns the addressed bank to normal reads. This applies at any point of a sequence except the data write of a program.
- R6: A write that does not match the next expected step of a sequence returns the decoder to its idle state, so a later 90h or A0h has no effect.
- R7: A program starts with the two unlock writes, then A0h, then one write of address and data. After that data write, `busy_o` shows the bank one-hot for exactly `PROG_CYCLES` cycles, starting in the cycle after the data write.
- R8: While a bank is busy, reads of that bank return the programmed word with bit 7 inverted. Reads of the other bank behave as usual.
- R9: While any bank is busy, every write is ignored, which includes a complete identification command.
- R10: Starting a program clears identification mode of its bank. When the program completes, the bank returns FFFFh.
- R11: A low `rst_ni` clears busy, identification mode, the decoder state and `rdata_o`, which becomes 0000h, from the next cycle on.
- R12: Read data appears on `rdata_o` in the cycle after `rd_i`, and it holds its value while `rd_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous hardware reset |
| wr_i | input | 1 | Write strobe, one cycle per bus write |
| rd_i | input | 1 | Read strobe, one cycle per bus read |
| addr_i | input | BANK_W+SECT_W+OFS_W | Word address {bank, sector, offset} |
| wdata_i | input | 16 | Write data; low byte carries the command |
| sect_lock_i | input | 2**(BANK_W+SECT_W) | Lock bit per sector, indexed by {bank, sector} |
| rdata_o | output | 16 | Registered read data |
| busy_o | output | 2**BANK_W | One-hot busy flag of the bank being programmed |

## Verification
The bench keeps the default address split: one bank bit, three sector bits and eight offset bits. This puts both banks and every sector lock bit within reach, and the unlock addresses fall inside the low eleven bits. It sets `PROG_CYCLES` to 12. That window is long enough to issue reads of both banks and a complete three-write identification command inside one busy period. It is also short enough to measure the whole busy length and to abort a program with the hardware reset part way through.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_UNL1,
        SEQ_UNL2,
        SEQ_PROG
    } seq_e;

    localparam int          UNLOCK_AW   = 11;
    localparam logic [10:0] UNLOCK_A1   = 11'h555;
    localparam logic [10:0] UNLOCK_A2   = 11'h2AA;
    localparam logic [7:0]  UNLOCK_D1   = 8'hAA;
    localparam logic [7:0]  UNLOCK_D2   = 8'h55;
    localparam logic [7:0]  CMD_AUTOSEL = 8'h90;
    localparam logic [7:0]  CMD_PROG    = 8'hA0;
    localparam logic [7:0]  CMD_RESET   = 8'hF0;
    localparam logic [15:0] ERASED_WORD = 16'hFFFF;
endpackage

// File: rtl/fc_seq_decoder.sv
module fc_seq_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BANK_W = 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        cmd_i,
    output logic              autosel_o,
    output logic              prog_o,
    output logic              reset_o,
    output logic [BANK_W-1:0] bank_o
);
    typedef struct packed {
        seq_e seq;
    } dec_t;

    dec_t st_d, st_q;
    logic [UNLOCK_AW-1:0] low_addr;

    assign low_addr = addr_i[UNLOCK_AW-1:0];
    assign bank_o   = addr_i[ADDR_W-1 -: BANK_W];

    always_comb begin
        st_d      = st_q;
        autosel_o = 1'b0;
        prog_o    = 1'b0;
        reset_o   = 1'b0;
        if (wr_i) begin
            if (st_q.seq == SEQ_PROG) begin
                prog_o     = 1'b1;
                st_d.seq   = SEQ_IDLE;
            end else if (cmd_i == CMD_RESET) begin
                reset_o    = 1'b1;
                st_d.seq   = SEQ_IDLE;
            end else begin
                unique case (st_q.seq)
                    SEQ_IDLE: st_d.seq = (low_addr == UNLOCK_A1 && cmd_i == UNLOCK_D1)
                                         ? SEQ_UNL1 : SEQ_IDLE;
                    SEQ_UNL1: st_d.seq = (low_addr == UNLOCK_A2 && cmd_i == UNLOCK_D2)
                                         ? SEQ_UNL2 : SEQ_IDLE;
                    SEQ_UNL2: begin
                        autosel_o = (cmd_i == CMD_AUTOSEL);
                        st_d.seq  = (cmd_i == CMD_PROG) ? SEQ_PROG : SEQ_IDLE;
                    end
                    default:  st_d.seq = SEQ_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '{seq: SEQ_IDLE};
        else         st_q <= st_d;
    end
endmodule

// File: rtl/fc_prog_timer.sv
module fc_prog_timer #(
    parameter int BANK_W      = 1,
    parameter int PROG_CYCLES = 20,
    localparam int NBANK = 2 ** BANK_W,
    localparam int CNT_W = $clog2(PROG_CYCLES + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [15:0]       data_i,
    output logic              busy_o,
    output logic [NBANK-1:0]  busy_vec_o,
    output logic [BANK_W-1:0] bank_o,
    output logic [15:0]       data_o
);
    typedef struct packed {
        logic              busy;
        logic [CNT_W-1:0]  cnt;
        logic [BANK_W-1:0] bank;
        logic [15:0]       data;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (st_q.cnt == '0) st_d.busy = 1'b0;
            else                st_d.cnt  = st_q.cnt - 1'b1;
        end
        if (start_i) begin
            st_d.busy = 1'b1;
            st_d.cnt  = CNT_W'(PROG_CYCLES - 1);
            st_d.bank = bank_i;
            st_d.data = data_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_busy
        assign busy_vec_o[b] = st_q.busy && (st_q.bank == BANK_W'(b));
    end

    assign busy_o = st_q.busy;
    assign bank_o = st_q.bank;
    assign data_o = st_q.data;
endmodule

// File: rtl/fc_read_port.sv
module fc_read_port
    import flash_cmd_pkg::*;
#(
    parameter int          BANK_W  = 1,
    parameter int          SECT_W  = 3,
    parameter int          OFS_W   = 8,
    parameter logic [15:0] MFR_ID  = 16'h0001,
    parameter logic [15:0] DEV_ID1 = 16'h5A10,
    parameter logic [15:0] DEV_ID2 = 16'h5A21,
    parameter logic [15:0] DEV_ID3 = 16'h5A00,
    localparam int ADDR_W = BANK_W + SECT_W + OFS_W,
    localparam int NBANK  = 2 ** BANK_W,
    localparam int NLOCK  = 2 ** (BANK_W + SECT_W)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [NBANK-1:0]  auto_i,
    input  logic              busy_i,
    input  logic [BANK_W-1:0] busy_bank_i,
    input  logic [15:0]       busy_data_i,
    input  logic [NLOCK-1:0]  lock_i,
    output logic [15:0]       rdata_o
);
    typedef struct packed {
        logic [15:0] rdata;
    } rd_t;

    rd_t st_d, st_q;
    logic [BANK_W-1:0]        bank;
    logic [BANK_W+SECT_W-1:0] lock_idx;
    logic [OFS_W-1:0]         ofs;
    logic [15:0]              id_word;

    assign bank     = addr_i[ADDR_W-1 -: BANK_W];
    assign lock_idx = addr_i[ADDR_W-1 -: BANK_W+SECT_W];
    assign ofs      = addr_i[OFS_W-1:0];

    always_comb begin
        unique case (ofs)
            OFS_W'(8'h00): id_word = MFR_ID;
            OFS_W'(8'h01): id_word = DEV_ID1;
            OFS_W'(8'h0E): id_word = DEV_ID2;
            OFS_W'(8'h0F): id_word = DEV_ID3;
            OFS_W'(8'h02): id_word = {15'd0, lock_i[lock_idx]};
            default:       id_word = 16'h0000;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (rd_i) begin
            if (busy_i && busy_bank_i == bank) st_d.rdata = busy_data_i ^ 16'h0080;
            else if (auto_i[bank])             st_d.rdata = id_word;
            else                               st_d.rdata = ERASED_WORD;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rdata_o = st_q.rdata;
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
    parameter int          BANK_W      = 1,
    parameter int          SECT_W      = 3,
    parameter int          OFS_W       = 8,
    parameter int          PROG_CYCLES = 20,
    parameter logic [15:0] DEV_ID1     = 16'h5A10,
    parameter logic [15:0] DEV_ID2     = 16'h5A21,
    parameter logic [15:0] DEV_ID3     = 16'h5A00,
    localparam int ADDR_W = BANK_W + SECT_W + OFS_W,
    localparam int NBANK  = 2 ** BANK_W,
    localparam int NLOCK  = 2 ** (BANK_W + SECT_W)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [15:0]       wdata_i,
    input  logic [NLOCK-1:0]  sect_lock_i,
    output logic [15:0]       rdata_o,
    output logic [NBANK-1:0]  busy_o
);
    typedef struct packed {
        logic [NBANK-1:0] auto_mode;
    } top_t;

    top_t st_d, st_q;
    logic              busy_any, wr_eff;
    logic              cmd_auto, cmd_prog, cmd_reset;
    logic [BANK_W-1:0] cmd_bank, busy_bank;
    logic [15:0]       busy_data;

    assign wr_eff = wr_i && !busy_any;

    fc_seq_decoder #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_dec (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_i      (wr_eff),
        .addr_i    (addr_i),
        .cmd_i     (wdata_i[7:0]),
        .autosel_o (cmd_auto),
        .prog_o    (cmd_prog),
        .reset_o   (cmd_reset),
        .bank_o    (cmd_bank)
    );

    fc_prog_timer #(.BANK_W(BANK_W), .PROG_CYCLES(PROG_CYCLES)) u_tmr (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .start_i    (cmd_prog),
        .bank_i     (cmd_bank),
        .data_i     (wdata_i),
        .busy_o     (busy_any),
        .busy_vec_o (busy_o),
        .bank_o     (busy_bank),
        .data_o     (busy_data)
    );

    always_comb begin
        st_d = st_q;
        for (int b = 0; b < NBANK; b++) begin
            if (cmd_bank == BANK_W'(b)) begin
                if (cmd_reset || cmd_prog) st_d.auto_mode[b] = 1'b0;
                if (cmd_auto)              st_d.auto_mode[b] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    fc_read_port #(
        .BANK_W (BANK_W), .SECT_W (SECT_W), .OFS_W (OFS_W),
        .DEV_ID1(DEV_ID1), .DEV_ID2(DEV_ID2), .DEV_ID3(DEV_ID3)
    ) u_rd (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .rd_i        (rd_i),
        .addr_i      (addr_i),
        .auto_i      (st_q.auto_mode),
        .busy_i      (busy_any),
        .busy_bank_i (busy_bank),
        .busy_data_i (busy_data),
        .lock_i      (sect_lock_i),
        .rdata_o     (rdata_o)
    );
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk #(
    parameter int NBANK = 2
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             wr_i,
    input logic             rd_i,
    input logic [15:0]      rdata_o,
    input logic [NBANK-1:0] busy_o
);
    // R7
    busy_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(busy_o));

    // R7
    busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(|busy_o) |-> $past(wr_i));

    // R9
    busy_wr_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && |busy_o) |=> (busy_o == $past(busy_o) || busy_o == '0));

    // R11
    hw_reset_chk: assert property (@(posedge clk_i)
        !rst_ni |=> (busy_o == '0 && rdata_o == 16'h0000));

    // R12
    rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_i |=> $stable(rdata_o));
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.NBANK(2 ** BANK_W)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .rd_i    (rd_i),
    .rdata_o (rdata_o),
    .busy_o  (busy_o)
);

// File: tb/flash_cmd_ctrl_test.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_test;
    localparam int          P    = 12;
    localparam logic [15:0] ID1  = 16'h5A10;
    localparam logic [15:0] ID2  = 16'h5A21;
    localparam logic [15:0] ID3  = 16'h5A00;
    localparam logic [15:0] LOCK = 16'hA5C3;

    logic        clk = 0, rst_n = 0, wr = 0, rd = 0;
    logic [11:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [1:0]  busy;

    always #2.5 clk = ~clk;

    flash_cmd_ctrl #(.PROG_CYCLES(P), .DEV_ID1(ID1), .DEV_ID2(ID2), .DEV_ID3(ID3)) uut (
        .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr),
        .wdata_i(wdata), .sect_lock_i(LOCK), .rdata_o(rdata), .busy_o(busy)
    );

    int errors = 0, checks = 0;

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // behavioural reference model
    int          m_seq = 0, m_cnt = 0, m_bank = 0, m_b, m_ofs, m_sec;
    bit          m_auto[2] = '{0, 0};
    bit          m_busy = 0, m_busy_pre;
    logic [15:0] m_pdata = 0, m_rdata = 0;
    logic [7:0]  m_d;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_seq = 0; m_busy = 0; m_cnt = 0; m_auto[0] = 0; m_auto[1] = 0; m_rdata = 0;
        end else begin
            m_busy_pre = m_busy;
            m_b   = int'(addr[11]);
            m_ofs = int'(addr[7:0]);
            m_sec = int'(addr[10:8]);
            if (rd) begin
                if (m_busy && m_bank == m_b) m_rdata = m_pdata ^ 16'h0080;
                else if (m_auto[m_b]) begin
                    case (m_ofs)
                        0: m_rdata = 16'h0001;
                        1: m_rdata = ID1;
                        14: m_rdata = ID2;
                        15: m_rdata = ID3;
                        2: m_rdata = {15'd0, LOCK[m_b * 8 + m_sec]};
                        default: m_rdata = 16'h0000;
                    endcase
                end else m_rdata = 16'hFFFF;
            end
            if (m_busy) begin
                if (m_cnt == 0) m_busy = 0; else m_cnt--;
            end
            if (wr && !m_busy_pre) begin
                m_d = wdata[7:0];
                if (m_seq == 3) begin
                    m_busy = 1; m_cnt = P - 1; m_bank = m_b; m_pdata = wdata;
                    m_auto[m_b] = 0; m_seq = 0;
                end else if (m_d == 8'hF0) begin
                    m_auto[m_b] = 0; m_seq = 0;
                end else if (m_seq == 0) m_seq = (addr[10:0] == 11'h555 && m_d == 8'hAA) ? 1 : 0;
                else if (m_seq == 1)     m_seq = (addr[10:0] == 11'h2AA && m_d == 8'h55) ? 2 : 0;
                else begin
                    if (m_d == 8'h90) m_auto[m_b] = 1;
                    m_seq = (m_d == 8'hA0) ? 3 : 0;
                end
            end
        end
    end

    // per-cycle comparison and busy-length monitor
    int run_len = 0, last_len = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R7 busy vs model", {14'd0, busy}, m_busy ? (16'd1 << m_bank) : 16'd0);
            chk("R12 rdata vs model", rdata, m_rdata);
        end
        if (busy != 0) run_len++;
        else if (run_len != 0) begin last_len = run_len; run_len = 0; end
    end

    task automatic bus_wr(logic [11:0] a, logic [15:0] d);
        @(negedge clk); wr = 1; addr = a; wdata = d;
        @(negedge clk); wr = 0;
    endtask

    task automatic bus_rd(logic [11:0] a, output logic [15:0] d);
        @(negedge clk); rd = 1; addr = a;
        @(negedge clk); rd = 0; d = rdata;
    endtask

    task automatic unlock(logic [11:0] bank_base, logic [7:0] cmd);
        bus_wr(12'h555, 16'h00AA);
        bus_wr(12'h2AA, 16'h0055);
        bus_wr(bank_base, {8'h00, cmd});
    endtask

    task automatic wait_idle();
        while (busy != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual hang expected finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        chk("R11 reset rdata", rdata, 16'h0000);
        chk("R11 reset busy", {14'd0, busy}, 16'h0000);
        rst_n = 1;

        bus_rd(12'h000, v); chk("R4 read mode bank0", v, 16'hFFFF);

        unlock(12'h800, 8'h90);
        bus_rd(12'h800, v); chk("R1 R2 manufacturer", v, 16'h0001);
        bus_rd(12'h801, v); chk("R2 id word1", v, ID1);
        bus_rd(12'h80E, v); chk("R2 id word2", v, ID2);
        bus_rd(12'hB0F, v); chk("R2 id word3 other sector", v, ID3);
        bus_rd(12'h800, v); chk("R2 repeat read", v, 16'h0001);
        bus_rd(12'h802, v); chk("R3 lock sector 8", v, 16'h0001);
        bus_rd(12'h902, v); chk("R3 lock sector 9", v, 16'h0000);
        bus_rd(12'hA02, v); chk("R3 lock sector 10", v, 16'h0001);
        bus_rd(12'h805, v); chk("R4 other offset", v, 16'h0000);
        bus_rd(12'h000, v); chk("R4 other bank", v, 16'hFFFF);

        repeat (3) @(negedge clk);
        chk("R12 hold", rdata, 16'hFFFF);

        bus_wr(12'h555, 16'h00AA); bus_wr(12'h2AA, 16'h0012); bus_wr(12'h000, 16'h0090);
        bus_rd(12'h000, v); chk("R6 broken sequence", v, 16'hFFFF);

        bus_wr(12'h800, 16'h00F0);
        bus_rd(12'h800, v); chk("R5 reset command", v, 16'hFFFF);

        unlock(12'h000, 8'h90);
        bus_rd(12'h000, v); chk("R1 bank0 autoselect", v, 16'h0001);
        unlock(12'h000, 8'hA0);
        bus_wr(12'h123, 16'h0042);
        chk("R7 busy right after data write", {14'd0, busy}, 16'h0001);
        bus_rd(12'h010, v); chk("R8 busy bank read", v, 16'h00C2);
        bus_rd(12'h800, v); chk("R8 other bank read", v, 16'hFFFF);
        unlock(12'h800, 8'h90);
        wait_idle();
        chk("R7 busy length", 16'(last_len), 16'(P));
        bus_rd(12'h800, v); chk("R9 autoselect refused", v, 16'hFFFF);
        bus_rd(12'h000, v); chk("R10 after program", v, 16'hFFFF);

        unlock(12'h800, 8'hA0);
        bus_wr(12'h8F0, 16'h00FF);
        bus_rd(12'h8F0, v); chk("R8 data bit7 set", v, 16'h007F);
        chk("R7 bank1 busy", {14'd0, busy}, 16'h0002);
        wait_idle();

        unlock(12'h800, 8'h90);
        unlock(12'h000, 8'hA0);
        bus_wr(12'h044, 16'h1234);
        repeat (3) @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        chk("R11 abort busy", {14'd0, busy}, 16'h0000);
        chk("R11 abort rdata", rdata, 16'h0000);
        rst_n = 1;
        bus_rd(12'h800, v); chk("R11 autoselect cleared", v, 16'hFFFF);
        bus_rd(12'h044, v); chk("R11 program aborted", v, 16'hFFFF);

        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule